// File: doc/BRIEF.md
# Dual Register Logic Cell

This block is the storage half of a programmable logic cell. It holds two single-bit storage elements, X (element 0) and Y (element 1). Four general control inputs pass through programmable selectors onto four internal signals: clock enable, local set/reset, direct data and an auxiliary input for the cell's third function generator. Each element loads its next value from one of three function-generator results or from the direct data signal. Each output can either show the stored bit or feed one of the control inputs straight through.

All options come from static configuration ports. One bit per element picks its preset polarity. That single choice fixes three things: the value after a configuration load, the value under global set/reset, and the value under local set/reset. The global set/reset has its own input with an optional inverter, so it does not use the control routing. The function generators are not modelled here; their results arrive as plain inputs.

Top module: `dual_reg_cell`

## Requirements
- R1: `cfgInitSet[e]` (bit 0 = X, bit 1 = Y) is the preset value of element e. While `cfgLoad` is high, element e is forced asynchronously to that value.
- R2: The global set/reset is active when `gsrIn ^ cfgGsrInv` is 1. While it is active, every element is held at its preset value, whatever `cfgSrEn` is.
- R3: The local set/reset is an active-high asynchronous signal taken from the routed control input. It forces element e to its preset value only when `cfgSrEn[e]` is 1. When `cfgSrEn[e]` is 0 it has no effect on that element.
- R4: Any asserted set/reset wins over the clock and the clock enable. A forced element keeps its preset value across rising edges even when the enable is high.
- R5: `cfgRoute` holds four 2-bit control-input indices. Bits [1:0] select the clock enable, [3:2] the local set/reset, [5:4] the direct data and [7:6] the auxiliary signal. `auxOut` equals `ctrlIn` at the auxiliary index.
- R6: `cfgDSel[2e+1:2e]` selects the D source of element e: 0 = `funcIn[0]` (F), 1 = `funcIn[1]` (G), 2 = `funcIn[2]` (H), 3 = direct data. The selected value is captured on a rising clock edge when the routed enable is 1.
- R7: When the routed clock enable is 0 on a rising edge and no set/reset is active, the element holds its value.
- R8: When `cfgBypEn[e]` is 1, `cellOut[e]` equals `ctrlIn[cfgBypSel[2e+1:2e]]` combinationally. When it is 0, `cellOut[e]` shows the stored bit of element e.
- R9: The two elements are configured independently. Each one's D source, preset, local set/reset enable and bypass act only on that element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock, rising edge |
| gsrIn | input | 1 | Global set/reset line before the optional inverter |
| cfgGsrInv | input | 1 | Inverts the global set/reset line when 1 |
| cfgLoad | input | 1 | Configuration-load pulse; forces the preset values |
| ctrlIn | input | 4 | General control inputs |
| funcIn | input | 3 | Function results: bit 0 F, bit 1 G, bit 2 H |
| cfgRoute | input | 8 | Control routing indices (enable, set/reset, direct data, auxiliary) |
| cfgInitSet | input | 2 | Preset polarity per element (1 = set, 0 = reset) |
| cfgSrEn | input | 2 | Local set/reset enable per element |
| cfgDSel | input | 4 | D source select, 2 bits per element |
| cfgBypEn | input | 2 | Output bypass enable per element |
| cfgBypSel | input | 4 | Bypass control-input index, 2 bits per element |
| cellOut | output | 2 | Cell outputs X (bit 0) and Y (bit 1) |
| auxOut | output | 1 | Routed auxiliary signal for the H function generator |

## Verification
A wrong stored bit shows at `cellOut` as soon as the bypass for that element is off. A bad capture is visible in the cycle after the rising edge. A bad force shows within a delta of the set/reset edge, because the preset is asynchronous. A fault in the routing selectors shows in several places: at `auxOut` at once, as a missed or spurious capture at the next edge, or as an element that ignores its local set/reset. The sweeps cover every routing index, D source, bypass index and preset polarity. Because of that, a selector wired to the wrong input gives a different output bit within one clock.

// File: rtl/dual_reg_cell_pkg.sv
package dual_reg_cell_pkg;
  localparam int CELL_ELEMS  = 2;
  localparam int CTRL_COUNT  = 4;
  localparam int SEL_W       = $clog2(CTRL_COUNT);
  localparam int ROUTE_SLOTS = 4;
  localparam int FUNC_COUNT  = 3;
  localparam int DSRC_COUNT  = FUNC_COUNT + 1;
  localparam int DSEL_W      = $clog2(DSRC_COUNT);

  // slot order inside the routing word
  localparam int SLOT_EN  = 0;
  localparam int SLOT_SR  = 1;
  localparam int SLOT_DIR = 2;
  localparam int SLOT_AUX = 3;

  typedef struct packed {
    logic                  clkEn;
    logic                  dirIn;
    logic [CELL_ELEMS-1:0] forceHit;
  } cell_strobe_t;
endpackage

// File: rtl/dual_reg_cell_ctrl.sv
module dual_reg_cell_ctrl
  import dual_reg_cell_pkg::*;
(
  input  logic [CTRL_COUNT-1:0]        ctrlIn,
  input  logic [ROUTE_SLOTS*SEL_W-1:0] cfgRoute,
  input  logic                         gsrIn,
  input  logic                         cfgGsrInv,
  input  logic                         cfgLoad,
  input  logic [CELL_ELEMS-1:0]        cfgSrEn,
  output cell_strobe_t                 strobes,
  output logic                         auxSig,
  output logic                         globalForce
);
  logic [ROUTE_SLOTS-1:0] routed;

  // any control input may feed any internal slot
  for (genvar k = 0; k < ROUTE_SLOTS; k++) begin : g_route
    assign routed[k] = ctrlIn[cfgRoute[k*SEL_W +: SEL_W]];
  end

  assign globalForce = (gsrIn ^ cfgGsrInv) | cfgLoad;

  always_comb begin
    strobes.clkEn    = routed[SLOT_EN];
    strobes.dirIn    = routed[SLOT_DIR];
    strobes.forceHit = {CELL_ELEMS{globalForce}}
                     | ({CELL_ELEMS{routed[SLOT_SR]}} & cfgSrEn);
  end

  assign auxSig = routed[SLOT_AUX];
endmodule

// File: rtl/dual_reg_cell_dp.sv
module dual_reg_cell_dp
  import dual_reg_cell_pkg::*;
(
  input  logic                         clk,
  input  cell_strobe_t                 strobes,
  input  logic [FUNC_COUNT-1:0]        funcIn,
  input  logic [CTRL_COUNT-1:0]        ctrlIn,
  input  logic [CELL_ELEMS-1:0]        cfgInitSet,
  input  logic [CELL_ELEMS*DSEL_W-1:0] cfgDSel,
  input  logic [CELL_ELEMS-1:0]        cfgBypEn,
  input  logic [CELL_ELEMS*SEL_W-1:0]  cfgBypSel,
  output logic [CELL_ELEMS-1:0]        qState,
  output logic [CELL_ELEMS-1:0]        cellOut
);
  logic [DSRC_COUNT-1:0] srcVec;
  assign srcVec = {strobes.dirIn, funcIn};

  for (genvar e = 0; e < CELL_ELEMS; e++) begin : g_elem
    logic forceE;
    logic dNext;
    logic qBit;

    assign forceE = strobes.forceHit[e];
    assign dNext  = srcVec[cfgDSel[e*DSEL_W +: DSEL_W]];

    // asynchronous preset dominates clock and enable
    always_ff @(posedge clk or posedge forceE) begin
      if (forceE)             qBit <= cfgInitSet[e];
      else if (strobes.clkEn) qBit <= dNext;
    end

    assign qState[e]  = qBit;
    assign cellOut[e] = cfgBypEn[e] ? ctrlIn[cfgBypSel[e*SEL_W +: SEL_W]] : qBit;
  end
endmodule

// File: rtl/dual_reg_cell.sv
module dual_reg_cell
  import dual_reg_cell_pkg::*;
(
  input  logic                         clk,
  input  logic                         gsrIn,
  input  logic                         cfgGsrInv,
  input  logic                         cfgLoad,
  input  logic [CTRL_COUNT-1:0]        ctrlIn,
  input  logic [FUNC_COUNT-1:0]        funcIn,
  input  logic [ROUTE_SLOTS*SEL_W-1:0] cfgRoute,
  input  logic [CELL_ELEMS-1:0]        cfgInitSet,
  input  logic [CELL_ELEMS-1:0]        cfgSrEn,
  input  logic [CELL_ELEMS*DSEL_W-1:0] cfgDSel,
  input  logic [CELL_ELEMS-1:0]        cfgBypEn,
  input  logic [CELL_ELEMS*SEL_W-1:0]  cfgBypSel,
  output logic [CELL_ELEMS-1:0]        cellOut,
  output logic                         auxOut
);
  cell_strobe_t          strobes;
  logic                  globalForce;
  logic [CELL_ELEMS-1:0] qState;

  dual_reg_cell_ctrl u_ctrl (
    .ctrlIn      (ctrlIn),
    .cfgRoute    (cfgRoute),
    .gsrIn       (gsrIn),
    .cfgGsrInv   (cfgGsrInv),
    .cfgLoad     (cfgLoad),
    .cfgSrEn     (cfgSrEn),
    .strobes     (strobes),
    .auxSig      (auxOut),
    .globalForce (globalForce)
  );

  dual_reg_cell_dp u_dp (
    .clk        (clk),
    .strobes    (strobes),
    .funcIn     (funcIn),
    .ctrlIn     (ctrlIn),
    .cfgInitSet (cfgInitSet),
    .cfgDSel    (cfgDSel),
    .cfgBypEn   (cfgBypEn),
    .cfgBypSel  (cfgBypSel),
    .qState     (qState),
    .cellOut    (cellOut)
  );
endmodule

// File: rtl/dual_reg_cell_chk.sv
module dual_reg_cell_chk
  import dual_reg_cell_pkg::*;
(
  input logic                  clk,
  input logic                  globalForce,
  input cell_strobe_t          strobes,
  input logic [CELL_ELEMS-1:0] qState,
  input logic [CELL_ELEMS-1:0] cellOut,
  input logic [CELL_ELEMS-1:0] cfgBypEn,
  input logic [CELL_ELEMS-1:0] cfgInitSet
);
  // R1 / R2: a global force holds every element at its preset
  always @(negedge clk) begin
    if (globalForce) begin
      a_global_preset_r2: assert (qState == cfgInitSet)
        else $error("global force left an element off its preset");
    end
  end

  // R3 / R4: any element under force sits at its preset, edges notwithstanding
  p_local_force_r3: assert property (@(posedge clk) disable iff (globalForce)
    1'b1 |-> ((strobes.forceHit & (qState ^ cfgInitSet)) == '0));

  // R7: enable low and no force -> the stored bits do not move
  p_hold_r7: assert property (@(posedge clk) disable iff (globalForce)
    (!strobes.clkEn && strobes.forceHit == '0)
      |=> ($stable(qState) || strobes.forceHit != '0));

  // R8: without bypass the output shows the stored bit
  p_passthru_r8: assert property (@(posedge clk) disable iff (globalForce)
    1'b1 |-> (((~cfgBypEn) & (cellOut ^ qState)) == '0));
endmodule

bind dual_reg_cell dual_reg_cell_chk u_chk (
  .clk         (clk),
  .globalForce (globalForce),
  .strobes     (strobes),
  .qState      (qState),
  .cellOut     (cellOut),
  .cfgBypEn    (cfgBypEn),
  .cfgInitSet  (cfgInitSet)
);

// File: tb/dual_reg_cell_bench.sv
module dual_reg_cell_bench;
  logic       clk = 1'b0;
  logic       gsrIn = 1'b0;
  logic       cfgGsrInv = 1'b0;
  logic       cfgLoad = 1'b0;
  logic [3:0] ctrlIn = '0;
  logic [2:0] funcIn = '0;
  logic [7:0] cfgRoute = 8'b11_10_01_00;
  logic [1:0] cfgInitSet = 2'b10;
  logic [1:0] cfgSrEn = '0;
  logic [3:0] cfgDSel = '0;
  logic [1:0] cfgBypEn = '0;
  logic [3:0] cfgBypSel = '0;
  logic [1:0] cellOut;
  logic       auxOut;

  int checks = 0;
  int errors = 0;
  localparam logic [7:0] ROUTE_DEF = 8'b11_10_01_00;

  always #4 clk = ~clk;

  dual_reg_cell u_dual_reg_cell (
    .clk(clk), .gsrIn(gsrIn), .cfgGsrInv(cfgGsrInv), .cfgLoad(cfgLoad),
    .ctrlIn(ctrlIn), .funcIn(funcIn), .cfgRoute(cfgRoute),
    .cfgInitSet(cfgInitSet), .cfgSrEn(cfgSrEn), .cfgDSel(cfgDSel),
    .cfgBypEn(cfgBypEn), .cfgBypSel(cfgBypSel), .cellOut(cellOut), .auxOut(auxOut)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic midLow();
    @(negedge clk); #2;
  endtask

  // store v (bit0 -> X via F, bit1 -> Y via G) using the default routing
  task automatic loadAll(input logic [1:0] v);
    midLow();
    cfgRoute = ROUTE_DEF;
    cfgDSel  = 4'b01_00;
    funcIn   = {1'b0, v[1], v[0]};
    ctrlIn   = 4'b0001;
    @(posedge clk);
    midLow();
    ctrlIn   = '0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    #1 cfgLoad = 1'b1;
    midLow();
    chk("R1 preset after load", cellOut, 2'b10);
    cfgLoad = 1'b0;
    midLow();
    chk("R1 preset kept after load", cellOut, 2'b10);

    // R1: configuration load forces each preset polarity
    for (int init = 0; init < 4; init++) begin
      cfgInitSet = 2'(init);
      loadAll(~2'(init));
      chk("R6 capture before load", cellOut, ~2'(init));
      midLow();
      cfgLoad = 1'b1;
      #1 chk("R1 async load", cellOut, 2'(init));
      @(posedge clk); midLow();
      cfgLoad = 1'b0;
      #1 chk("R1 after load release", cellOut, 2'(init));
    end

    // R2 / R4: global set/reset with both inverter settings
    for (int inv = 0; inv < 2; inv++) begin
      for (int init = 0; init < 4; init++) begin
        midLow();
        cfgGsrInv = inv[0]; gsrIn = inv[0];
        cfgInitSet = 2'(init); cfgSrEn = '0;
        loadAll(~2'(init));
        midLow();
        gsrIn = ~inv[0];
        #1 chk("R2 global force", cellOut, 2'(init));
        funcIn = {1'b0, ~init[1], ~init[0]};
        ctrlIn = 4'b0001;
        @(posedge clk); midLow();
        chk("R4 global beats enable", cellOut, 2'(init));
        ctrlIn = '0; gsrIn = inv[0];
      end
    end
    midLow();
    cfgGsrInv = 1'b0; gsrIn = 1'b0;

    // R3 / R4 / R9: local set/reset over every route index and enable mask
    for (int srSel = 0; srSel < 4; srSel++) begin
      for (int en = 0; en < 4; en++) begin
        for (int init = 0; init < 4; init++) begin
          logic [1:0] ex;
          logic [1:0] enV;
          logic [1:0] inV;
          enV = 2'(en); inV = 2'(init);
          cfgSrEn = '0; cfgInitSet = inV;
          loadAll(~inV);
          midLow();
          cfgRoute = {2'd0, 2'd0, 2'(srSel), 2'((srSel + 1) % 4)};
          cfgSrEn  = enV;
          ctrlIn[srSel] = 1'b1;
          ex = (enV & inV) | (~enV & ~inV);
          #1 chk("R3 local force mask", cellOut, ex);
          ctrlIn[(srSel + 1) % 4] = 1'b1;
          @(posedge clk); midLow();
          chk("R4 local beats enable", cellOut, ex);
          ctrlIn = '0; cfgSrEn = '0;
        end
      end
    end

    // R6 / R9: every D source pair under every data pattern
    for (int dx = 0; dx < 4; dx++) begin
      for (int dy = 0; dy < 4; dy++) begin
        for (int p = 0; p < 16; p++) begin
          logic [3:0] pv;
          pv = 4'(p);
          midLow();
          cfgRoute = ROUTE_DEF;
          cfgDSel  = {2'(dy), 2'(dx)};
          funcIn   = pv[2:0];
          ctrlIn   = {1'b0, pv[3], 1'b0, 1'b1};
          @(posedge clk); midLow();
          ctrlIn = '0;
          chk("R6 source select", cellOut, {pv[dy], pv[dx]});
        end
      end
    end

    // R7: enable low holds
    for (int v = 0; v < 4; v++) begin
      loadAll(2'(v));
      midLow();
      funcIn = {1'b1, ~v[1], ~v[0]};
      ctrlIn = 4'b0100;
      @(posedge clk); @(posedge clk); midLow();
      chk("R7 hold with enable low", cellOut, 2'(v));
      ctrlIn = '0;
    end

    // R8: output bypass across all selects
    loadAll(2'b10);
    midLow();
    funcIn = 3'b010;
    for (int be = 0; be < 4; be++) begin
      for (int sx = 0; sx < 4; sx++) begin
        for (int sy = 0; sy < 4; sy++) begin
          for (int c = 0; c < 16; c++) begin
            logic [1:0] ex;
            logic [3:0] cv;
            logic [1:0] bv;
            cv = 4'(c); bv = 2'(be);
            cfgBypEn  = bv;
            cfgBypSel = {2'(sy), 2'(sx)};
            ctrlIn    = cv;
            ex[0] = bv[0] ? cv[sx] : 1'b0;
            ex[1] = bv[1] ? cv[sy] : 1'b1;
            #1 chk("R8 bypass select", cellOut, ex);
          end
        end
      end
    end
    cfgBypEn = '0; ctrlIn = '0;

    // R5: auxiliary route
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 16; c++) begin
        logic [3:0] cv;
        cv = 4'(c);
        cfgRoute = {2'(s), 2'd2, 2'd1, 2'd0};
        cfgSrEn  = '0;
        ctrlIn   = cv;
        #1 chk("R5 aux route", {1'b0, auxOut}, {1'b0, cv[s]});
      end
    end

    finishRun();
  end
endmodule